// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches three external interrupt pins that are asynchronous to the system clock. Each pin is synchronized, optionally cleaned by a digital glitch filter, and checked for rising and/or falling transitions. An accepted transition sets a sticky per-channel status flag. The flag then becomes either an interrupt or a DMA request, depending on a per-channel select bit. All of this is gated by a per-channel request enable.

The three interrupt channels share two interrupt vector outputs. Channels 0 and 1 are merged onto vector 0, and channel 2 drives vector 1. Each channel also has its own DMA request line with a matching acknowledge input. A single prescaler sets the rate at which every filter counter advances. Each filter has its own acceptance count.

Software sets up and services the block over a simple synchronous register bus. Writes are single-cycle strobes. Read data is combinational from the address.

Top module: `eirq_top`

## Requirements
- R1: While reset is held and just after it, `irqVec` and `dmaReq` are 0. Every register reads 0. This covers: status at address 0, request enable at 1, DMA select at 2, rising enable at 3, falling enable at 4, filter enable at 5, prescaler at 6, and the filter limits for channels 0, 1 and 2 at addresses 7, 8 and 9.
- R2: A pin level passes two synchronizer flops, so its effect is delayed. With the filter off, the status flag becomes visible after the third rising clock edge that follows the pin change, and not after the second.
- R3: Bit n of the rising-enable register makes a 0-to-1 transition of channel n's filtered level set the flag. Bit n of the falling-enable register does the same for a 1-to-0 transition. Setting both makes either edge set it. Setting neither means the edge sets nothing.
- R4: When bit n of the filter-enable register is 0, the synchronized level of channel n goes straight to edge detection.
- R5: When the filter is enabled, a differing synchronized level is accepted on the filter tick at which it has been seen on max(L,1) consecutive ticks, where L is the channel's 4-bit filter limit. A return to the current filtered level restarts the count, so shorter glitches are rejected.
- R6: The 8-bit prescaler value P produces one filter tick every P+1 system clocks.
- R7: Status flags (bit n = channel n at address 0) are sticky. Writing 1 to a bit clears it, and writing 0 has no effect.
- R8: Channel n requests an interrupt when its flag, its request-enable bit and a 0 DMA-select bit are all set. `irqVec[0]` is the OR of channels 0 and 1, and `irqVec[1]` is channel 2.
- R9: With DMA-select bit n set, the enabled flag drives `dmaReq[n]` instead of an interrupt, and `dmaAck[n]` clears the flag. With the select bit 0, `dmaAck[n]` is ignored.
- R10: Configuration registers read back what was written, limited to their width: 3 bits for the enable and select registers, 8 bits for the prescaler, 4 bits for each limit.
- R11: If an edge event and a clear (a write of 1 or an acknowledge) happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 3 | External interrupt pins, asynchronous |
| dmaAck | input | 3 | Per-channel DMA acknowledge |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for `busAddr` |
| irqVec | output | 2 | Interrupt vector requests |
| dmaReq | output | 3 | Per-channel DMA requests |

## Verification
The bench targets the following corner cases:

- **Synchronizer latency.** An off-by-one here would move the flag one cycle early or late.
- **Glitch one tick shorter than the limit.** A filter that forgot to restart its count would accept the glitch.
- **Prescaler period.** An error in the P+1 divide would make the slow channel fire too soon.
- **Clear arriving in the same cycle as a new edge.** Wrong priority would silently lose that event.
- **Acknowledge on a channel in interrupt mode.** A design that ignores the select bit would wipe a pending interrupt.
- **Masking and the vector merge.** Mistakes here would route channel 2 onto the wrong vector, or leak requests from disabled channels.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  parameter int NCH     = 3;
  parameter int NVEC    = 2;
  parameter int PRESC_W = 8;
  parameter int FCNT_W  = 4;
  parameter int ADDR_W  = 4;
  parameter int DATA_W  = 8;

  localparam int A_STAT  = 0;
  localparam int A_REQEN = 1;
  localparam int A_SEL   = 2;
  localparam int A_RISE  = 3;
  localparam int A_FALL  = 4;
  localparam int A_FILT  = 5;
  localparam int A_PRESC = 6;
  localparam int A_FMAX0 = 7;

  typedef struct packed {
    logic [NCH-1:0]             reqEn;
    logic [NCH-1:0]             dmaSel;
    logic [NCH-1:0]             riseEn;
    logic [NCH-1:0]             fallEn;
    logic [NCH-1:0]             filtEn;
    logic [PRESC_W-1:0]         presc;
    logic [NCH-1:0][FCNT_W-1:0] fmax;
  } cfg_t;

  typedef struct packed {
    logic [NCH-1:0] flagClr;
  } strb_t;

  function automatic int vecOf(int ch);
    return (ch < 2) ? 0 : 1;
  endfunction
endpackage

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NCH-1:0]    flags,
  output cfg_t              cfg,
  output strb_t             strb,
  output logic [DATA_W-1:0] busRdata
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (busWr) begin
      case (busAddr)
        ADDR_W'(A_REQEN): cfg.reqEn  <= busWdata[NCH-1:0];
        ADDR_W'(A_SEL):   cfg.dmaSel <= busWdata[NCH-1:0];
        ADDR_W'(A_RISE):  cfg.riseEn <= busWdata[NCH-1:0];
        ADDR_W'(A_FALL):  cfg.fallEn <= busWdata[NCH-1:0];
        ADDR_W'(A_FILT):  cfg.filtEn <= busWdata[NCH-1:0];
        ADDR_W'(A_PRESC): cfg.presc  <= busWdata[PRESC_W-1:0];
        default: begin
          for (int ch = 0; ch < NCH; ch++) begin
            if (busAddr == ADDR_W'(A_FMAX0 + ch))
              cfg.fmax[ch] <= busWdata[FCNT_W-1:0];
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.flagClr = '0;
    if (busWr && busAddr == ADDR_W'(A_STAT))
      strb.flagClr = busWdata[NCH-1:0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(A_STAT):  busRdata = DATA_W'(flags);
      ADDR_W'(A_REQEN): busRdata = DATA_W'(cfg.reqEn);
      ADDR_W'(A_SEL):   busRdata = DATA_W'(cfg.dmaSel);
      ADDR_W'(A_RISE):  busRdata = DATA_W'(cfg.riseEn);
      ADDR_W'(A_FALL):  busRdata = DATA_W'(cfg.fallEn);
      ADDR_W'(A_FILT):  busRdata = DATA_W'(cfg.filtEn);
      ADDR_W'(A_PRESC): busRdata = DATA_W'(cfg.presc);
      default: begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (busAddr == ADDR_W'(A_FMAX0 + ch))
            busRdata = DATA_W'(cfg.fmax[ch]);
        end
      end
    endcase
  end
endmodule

// File: rtl/eirq_dp.sv
module eirq_dp
  import eirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NCH-1:0]  pinIn,
  input  logic [NCH-1:0]  dmaAck,
  input  cfg_t            cfg,
  input  strb_t           strb,
  output logic [NCH-1:0]  flags,
  output logic [NCH-1:0]  filtLvl,
  output logic            filtTick,
  output logic [NVEC-1:0] irqVec,
  output logic [NCH-1:0]  dmaReq
);
  logic [PRESC_W-1:0] pCnt;

  assign filtTick = (pCnt == cfg.presc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pCnt <= '0;
    else if (filtTick) pCnt <= '0;
    else pCnt <= pCnt + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic              syncA, syncB, lvlNxt, evt, clr;
    logic [FCNT_W-1:0] cnt, cntNxt;

    always_comb begin
      lvlNxt = filtLvl[i];
      cntNxt = cnt;
      if (!cfg.filtEn[i]) begin
        lvlNxt = syncB;
        cntNxt = '0;
      end else if (syncB == filtLvl[i]) begin
        cntNxt = '0;
      end else if (filtTick) begin
        if ((FCNT_W+1)'(cnt) + 1'b1 >= (FCNT_W+1)'(cfg.fmax[i])) begin
          lvlNxt = syncB;
          cntNxt = '0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
    end

    assign evt = (!filtLvl[i] && lvlNxt && cfg.riseEn[i]) ||
                 (filtLvl[i] && !lvlNxt && cfg.fallEn[i]);
    assign clr = strb.flagClr[i] || (dmaAck[i] && cfg.dmaSel[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA      <= 1'b0;
        syncB      <= 1'b0;
        filtLvl[i] <= 1'b0;
        cnt        <= '0;
        flags[i]   <= 1'b0;
      end else begin
        syncA      <= pinIn[i];
        syncB      <= syncA;
        filtLvl[i] <= lvlNxt;
        cnt        <= cntNxt;
        if (evt) flags[i] <= 1'b1;
        else if (clr) flags[i] <= 1'b0;
      end
    end
  end

  logic [NCH-1:0] irqCh;
  assign irqCh  = flags & cfg.reqEn & ~cfg.dmaSel;
  assign dmaReq = flags & cfg.reqEn & cfg.dmaSel;

  always_comb begin
    irqVec = '0;
    for (int ch = 0; ch < NCH; ch++)
      irqVec[vecOf(ch)] = irqVec[vecOf(ch)] | irqCh[ch];
  end
endmodule

// File: rtl/eirq_top.sv
module eirq_top
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    pinIn,
  input  logic [NCH-1:0]    dmaAck,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NVEC-1:0]   irqVec,
  output logic [NCH-1:0]    dmaReq
);
  cfg_t           cfg;
  strb_t          strb;
  logic [NCH-1:0] flagVec;
  logic [NCH-1:0] filtLvl;
  logic           filtTick;

  eirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .flags(flagVec), .cfg(cfg), .strb(strb),
    .busRdata(busRdata)
  );

  eirq_dp u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dmaAck(dmaAck), .cfg(cfg),
    .strb(strb), .flags(flagVec), .filtLvl(filtLvl), .filtTick(filtTick),
    .irqVec(irqVec), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NVEC-1:0]   irqVec,
  input logic [NCH-1:0]    dmaReq,
  input logic [NCH-1:0]    dmaAck,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    filtLvl,
  input logic              filtTick,
  input logic [NCH-1:0]    filtEn,
  input logic [PRESC_W-1:0] presc
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqVec == '0 && dmaReq == '0 && flags == '0));

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtTick && presc != '0 && !busWr) |=> !filtTick);

  // R9
  dma_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq[2] |-> !irqVec[1]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |->
        ($past(busWr && busAddr == ADDR_W'(A_STAT) && busWdata[i]) || $past(dmaAck[i])));

    // R3
    flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> (filtLvl[i] != $past(filtLvl[i])));

    // R5
    filt_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      (filtEn[i] && $past(filtEn[i]) && filtLvl[i] != $past(filtLvl[i])) |-> $past(filtTick));
  end
endmodule

bind eirq_top eirq_chk u_chk (
  .clk(clk), .rstN(rstN), .irqVec(irqVec), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .flags(flagVec),
  .filtLvl(filtLvl), .filtTick(filtTick), .filtEn(cfg.filtEn), .presc(cfg.presc)
);

// File: tb/sim_eirq_top.sv
module sim_eirq_top;
  import eirq_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic [2:0] pinIn = '0, dmaAck = '0;
  logic       busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [1:0] irqVec;
  logic [2:0] dmaReq;

  eirq_top u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dmaAck(dmaAck), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqVec(irqVec), .dmaReq(dmaReq)
  );

  int checks = 0, fails = 0;
  bit live = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_s1[3], m_s2[3], m_lvl[3], m_flag[3];
  int m_cnt[3], m_fmax[3];
  int m_pcnt, m_presc;
  bit [2:0] m_en, m_sel, m_rise, m_fall, m_fen;
  bit tk, nl, ev, cl;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_lvl[c] = 0; m_flag[c] = 0;
        m_cnt[c] = 0; m_fmax[c] = 0;
      end
      m_pcnt = 0; m_presc = 0;
      m_en = 0; m_sel = 0; m_rise = 0; m_fall = 0; m_fen = 0;
    end else begin
      tk = (m_pcnt == m_presc);
      for (int c = 0; c < 3; c++) begin
        nl = m_lvl[c];
        if (!m_fen[c]) begin
          nl = m_s2[c]; m_cnt[c] = 0;
        end else if (m_s2[c] == m_lvl[c]) begin
          m_cnt[c] = 0;
        end else if (tk) begin
          if (m_cnt[c] + 1 >= m_fmax[c]) begin nl = m_s2[c]; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end
        ev = (!m_lvl[c] && nl && m_rise[c]) || (m_lvl[c] && !nl && m_fall[c]);
        cl = (busWr && busAddr == 0 && busWdata[c]) || (dmaAck[c] && m_sel[c]);
        if (ev) m_flag[c] = 1; else if (cl) m_flag[c] = 0;
        m_lvl[c] = nl;
        m_s2[c] = m_s1[c];
        m_s1[c] = pinIn[c];
      end
      m_pcnt = tk ? 0 : (m_pcnt + 1) % 256;
      if (busWr) begin
        case (busAddr)
          1: m_en = busWdata[2:0];
          2: m_sel = busWdata[2:0];
          3: m_rise = busWdata[2:0];
          4: m_fall = busWdata[2:0];
          5: m_fen = busWdata[2:0];
          6: m_presc = busWdata;
          7, 8, 9: m_fmax[busAddr-7] = busWdata[3:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit [2:0] mFlags();
    return {m_flag[2], m_flag[1], m_flag[0]};
  endfunction

  function automatic bit [7:0] mRd(bit [3:0] a);
    case (a)
      0: return {5'b0, mFlags()};
      1: return {5'b0, m_en};
      2: return {5'b0, m_sel};
      3: return {5'b0, m_rise};
      4: return {5'b0, m_fall};
      5: return {5'b0, m_fen};
      6: return 8'(m_presc);
      7, 8, 9: return 8'(m_fmax[a-7]);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN && live) begin
      bit [2:0] irq, expDma;
      bit [1:0] expVec;
      irq = mFlags() & m_en & ~m_sel;
      expDma = mFlags() & m_en & m_sel;
      expVec = {irq[2], irq[0] | irq[1]};
      chk(irqVec == expVec, "R8", irqVec, expVec);
      chk(dmaReq == expDma, "R9", dmaReq, expDma);
      chk(busRdata == mRd(busAddr), "R10", busRdata, mRd(busAddr));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    busWr = 1; busAddr = 4'(a); busWdata = 8'(d);
    step(1);
    busWr = 0;
  endtask

  task automatic rdChk(int a, int mask, int exp, string req);
    busAddr = 4'(a);
    #1;
    chk((busRdata & 8'(mask)) == 8'(exp), req, busRdata & 8'(mask), exp);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk(irqVec == 0 && dmaReq == 0, "R1", {irqVec, dmaReq}, 0);
    for (int a = 0; a < 10; a++) rdChk(a, 8'hFF, 0, "R1");
    rstN = 1;
    live = 1;
    step(1);
    chk(irqVec == 0 && dmaReq == 0, "R1", {irqVec, dmaReq}, 0);

    // R2/R4 sync latency, filter off
    wr(A_RISE, 1); wr(A_REQEN, 7);
    pinIn[0] = 1;
    step(2); rdChk(A_STAT, 1, 0, "R2");
    step(1); rdChk(A_STAT, 1, 1, "R4");
    chk(irqVec == 2'b01, "R8", irqVec, 1);

    // R7 sticky, write 0 no effect, write 1 clears
    wr(A_STAT, 0); step(1); rdChk(A_STAT, 1, 1, "R7");
    wr(A_STAT, 1); step(1); rdChk(A_STAT, 1, 0, "R7");

    // R3 falling with fall disabled: nothing
    pinIn[0] = 0; step(6); rdChk(A_STAT, 1, 0, "R3");
    // both edges on ch1
    wr(A_RISE, 3); wr(A_FALL, 2);
    pinIn[1] = 1; step(6); rdChk(A_STAT, 2, 2, "R3");
    wr(A_STAT, 2);
    pinIn[1] = 0; step(6); rdChk(A_STAT, 2, 2, "R3");
    wr(A_STAT, 7);

    // R8 ch2 onto vector 1, masking
    wr(A_RISE, 7);
    pinIn[2] = 1; step(6);
    chk(irqVec == 2'b10, "R8", irqVec, 2);
    wr(A_REQEN, 3); step(1);
    chk(irqVec == 0, "R8", irqVec, 0);
    rdChk(A_STAT, 4, 4, "R8");
    wr(A_REQEN, 7);

    // R9 DMA routing and ack
    wr(A_SEL, 4); step(1);
    chk(dmaReq == 3'b100 && irqVec == 0, "R9", {irqVec, dmaReq}, 4);
    dmaAck[2] = 1; step(1); dmaAck[2] = 0; step(1);
    chk(dmaReq == 0, "R9", dmaReq, 0);
    rdChk(A_STAT, 4, 0, "R9");
    pinIn[0] = 1; step(6);
    dmaAck[0] = 1; step(1); dmaAck[0] = 0; step(1);
    rdChk(A_STAT, 1, 1, "R9");
    wr(A_STAT, 7);

    // R5 filter on ch1, presc 0, limit 4
    wr(A_PRESC, 0); wr(A_FMAX0 + 1, 4); wr(A_FILT, 2);
    pinIn[1] = 1; step(2); pinIn[1] = 0; step(10);
    rdChk(A_STAT, 2, 0, "R5");
    pinIn[1] = 1; step(3); pinIn[1] = 1; step(0);
    pinIn[1] = 1;
    step(2); rdChk(A_STAT, 2, 0, "R5");
    step(6); rdChk(A_STAT, 2, 2, "R5");
    wr(A_STAT, 7);

    // R6 prescaler on ch2 falling, presc 3, limit 2
    wr(A_FALL, 7); wr(A_PRESC, 3); wr(A_FMAX0 + 2, 2); wr(A_FILT, 6);
    pinIn[2] = 0; step(5); rdChk(A_STAT, 4, 0, "R6");
    step(20); rdChk(A_STAT, 4, 4, "R6");
    wr(A_STAT, 7);

    // R11 set wins over same-cycle clear on ch0 (filter off)
    wr(A_SEL, 0);
    pinIn[0] = 0; step(2);
    wr(A_STAT, 1);
    rdChk(A_STAT, 1, 1, "R11");

    // R10 readback widths
    wr(A_PRESC, 8'hA5); rdChk(A_PRESC, 8'hFF, 8'hA5, "R10");
    wr(A_FMAX0, 8'hF9); rdChk(A_FMAX0, 8'hFF, 9, "R10");
    wr(A_REQEN, 8'hFF); rdChk(A_REQEN, 8'hFF, 7, "R10");
    step(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule